// File: doc/BRIEF.md
# Gated Timebase Event Counter with Result Latch

This block measures a time interval or totals events by counting timebase ticks while a measurement gate is held high. A free-running prescaler splits the reference clock into a medium tick and a slow tick. With the default settings and a 10 MHz reference, the medium tick divides the clock by 100 (10 µs) and the slow tick divides it by 100,000 in total (10 ms). A two-bit rate select picks the full clock rate, the medium tick or the slow tick. A fourth setting totals gate pulses instead of timing them.

The count is kept in decimal (BCD) digits. When the gate logic signals the end of a measurement with a one-cycle done pulse, the count is copied into display registers. In the timed modes the counter is then zeroed on the next cycle, ready for the next gate. The prescaler never restarts with the gate, so the first tick inside a gate can land anywhere in its period. This gives the usual plus or minus one count of resolution.

Top module: `gated_count_latch`

## Requirements
- R1: While reset is high and on the first cycle after it, `disp_bcd` is all zeros and `disp_ovf` is 0.
- R2: With `rate_sel` = 2'b01, the counter advances by one on every clock cycle in which `gate` is high.
- R3: With `rate_sel` = 2'b10, the counter advances once per DIV_MID clock cycles in which `gate` is high. With `rate_sel` = 2'b11 it advances once per DIV_MID*DIV_SLOW such cycles. The prescaler runs freely from reset and ignores the gate, so any gate window whose length is a whole number of tick periods gives an exact count.
- R4: In the timed modes (01, 10, 11), cycles in which `gate` is low add nothing to the count.
- R5: With `rate_sel` = 2'b00 (totalize), the counter advances by one for each low-to-high transition of `gate`. A done pulse in this mode latches the count but does not clear it.
- R6: On a cycle with `gate_done` high, the display takes the count including any increment of that same cycle, plus the overflow state. It shows them from the next cycle and holds them until the next `gate_done`.
- R7: After a `gate_done` cycle in a timed mode, the counter and overflow state are cleared on the next cycle. An increment in that clearing cycle is kept as the first count of the new measurement, so nothing is lost or counted twice.
- R8: Digit k of `disp_bcd` is at bits [4k+3:4k], with digit 0 least significant, and each digit is 0 to 9. An increment from all nines wraps to all zeros and sets overflow. Overflow is latched with the result and cleared together with the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Count source: 00 totalize, 01 clock, 10 medium tick, 11 slow tick |
| gate | input | 1 | Measurement gate level |
| gate_done | input | 1 | One-cycle end-of-measurement pulse |
| disp_bcd | output | 4*DIGITS | Latched BCD result, digit 0 in the low nibble |
| disp_ovf | output | 1 | Latched overflow flag |

## Verification
The bench builds the block with DIV_MID = 4, DIV_SLOW = 5 and DIGITS = 3. With these values a medium tick comes every 4 cycles and a slow tick every 20 cycles. The counter wraps after 999, so overflow and the wrap to zero can be reached in about a thousand cycles instead of a hundred thousand. Gate windows are whole multiples of the tick periods, which makes the count exact even though the prescaler phase is free-running. The same values also exercise a done pulse that lands on the last gate-high cycle and a gate that stays high through the clearing cycle.

// File: rtl/gtc_pkg.sv
package gtc_pkg;

    typedef enum logic [1:0] {
        RATE_TOTAL = 2'b00,
        RATE_CLK   = 2'b01,
        RATE_MID   = 2'b10,
        RATE_SLOW  = 2'b11
    } rate_e;

    typedef logic [3:0] bcd_t;

    localparam bcd_t BCD_MAX = 4'd9;

    function automatic bcd_t bcd_step(input bcd_t d);
        if (d == BCD_MAX) return 4'd0;
        return 4'(d + 4'd1);
    endfunction

endpackage

// File: rtl/gtc_tick_divider.sv
module gtc_tick_divider #(
    parameter int DIV_MID  = 100,
    parameter int DIV_SLOW = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_mid,
    output logic tick_slow
);
    localparam int W_MID  = (DIV_MID  > 1) ? $clog2(DIV_MID)  : 1;
    localparam int W_SLOW = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;
    localparam logic [W_MID-1:0]  MID_LAST  = W_MID'(DIV_MID - 1);
    localparam logic [W_SLOW-1:0] SLOW_LAST = W_SLOW'(DIV_SLOW - 1);

    logic [W_MID-1:0]  mid_q;
    logic [W_SLOW-1:0] slow_q;

    assign tick_mid  = (mid_q == MID_LAST);
    assign tick_slow = tick_mid && (slow_q == SLOW_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            mid_q <= '0;
        end else if (tick_mid) begin
            mid_q <= '0;
        end else begin
            mid_q <= mid_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slow_q <= '0;
        end else if (tick_mid) begin
            if (slow_q == SLOW_LAST) slow_q <= '0;
            else                     slow_q <= slow_q + 1'b1;
        end
    end

    AST_SLOW_ON_MID: assert property (@(posedge clk) disable iff (rst)
        tick_slow |-> tick_mid); // R3
    AST_MID_SPACED: assert property (@(posedge clk) disable iff (rst)
        (tick_mid && (DIV_MID > 1)) |=> !tick_mid); // R3

endmodule

// File: rtl/gtc_rate_select.sv
module gtc_rate_select
    import gtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rate_sel,
    input  logic       gate,
    input  logic       tick_mid,
    input  logic       tick_slow,
    output logic       inc
);
    rate_e rate;
    logic  gate_q;
    logic  gate_rise;

    assign rate      = rate_e'(rate_sel);
    assign gate_rise = gate && !gate_q;

    always_ff @(posedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= gate;
    end

    always_comb begin
        unique case (rate)
            RATE_TOTAL: inc = gate_rise;
            RATE_CLK:   inc = gate;
            RATE_MID:   inc = gate && tick_mid;
            RATE_SLOW:  inc = gate && tick_slow;
            default:    inc = 1'b0;
        endcase
    end

    AST_TOTAL_ONE_PER_EDGE: assert property (@(posedge clk) disable iff (rst)
        (rate == RATE_TOTAL && gate && gate_q) |-> !inc); // R5
    AST_TIMED_GATE_LOW: assert property (@(posedge clk) disable iff (rst)
        (rate != RATE_TOTAL && !gate) |-> !inc); // R4

endmodule

// File: rtl/gtc_bcd_accum.sv
module gtc_bcd_accum
    import gtc_pkg::*;
#(
    parameter int DIGITS = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  inc,
    input  logic                  clr,
    output logic [DIGITS*4-1:0]   cnt_value,
    output logic                  cnt_ovf,
    output logic [DIGITS*4-1:0]   next_value,
    output logic                  next_ovf
);
    localparam int W = DIGITS * 4;

    logic [W-1:0]    cur_q;
    logic            ovf_q;
    logic [W-1:0]    base;
    logic [DIGITS:0] carry;

    assign base     = clr ? '0 : cur_q;
    assign carry[0] = inc;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        assign carry[g+1] = carry[g] && (base[g*4 +: 4] == BCD_MAX);
        assign next_value[g*4 +: 4] = carry[g] ? bcd_step(base[g*4 +: 4])
                                               : base[g*4 +: 4];

        AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
            cur_q[g*4 +: 4] <= BCD_MAX); // R8
    end

    assign next_ovf = (clr ? 1'b0 : ovf_q) | carry[DIGITS];

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            cur_q <= next_value;
            ovf_q <= next_ovf;
        end
    end

    assign cnt_value = cur_q;
    assign cnt_ovf   = ovf_q;

    AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (rst)
        carry[DIGITS] |=> (ovf_q && cur_q == '0)); // R8

endmodule

// File: rtl/gtc_result_latch.sv
module gtc_result_latch #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] value_in,
    input  logic         ovf_in,
    output logic [W-1:0] value_out,
    output logic         ovf_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value_out <= '0;
            ovf_out   <= 1'b0;
        end else if (load) begin
            value_out <= value_in;
            ovf_out   <= ovf_in;
        end
    end
endmodule

// File: rtl/gated_count_latch.sv
module gated_count_latch
    import gtc_pkg::*;
#(
    parameter int DIV_MID  = 100,
    parameter int DIV_SLOW = 1000,
    parameter int DIGITS   = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           rate_sel,
    input  logic                 gate,
    input  logic                 gate_done,
    output logic [DIGITS*4-1:0]  disp_bcd,
    output logic                 disp_ovf
);
    localparam int W = DIGITS * 4;

    logic         tick_mid;
    logic         tick_slow;
    logic         inc;
    logic         clr_q;
    logic [W-1:0] cnt_value;
    logic         cnt_ovf;
    logic [W-1:0] next_value;
    logic         next_ovf;

    gtc_tick_divider #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_div (
        .clk       (clk),
        .rst       (rst),
        .tick_mid  (tick_mid),
        .tick_slow (tick_slow)
    );

    gtc_rate_select u_sel (
        .clk       (clk),
        .rst       (rst),
        .rate_sel  (rate_sel),
        .gate      (gate),
        .tick_mid  (tick_mid),
        .tick_slow (tick_slow),
        .inc       (inc)
    );

    always_ff @(posedge clk) begin
        if (rst) clr_q <= 1'b0;
        else     clr_q <= gate_done && (rate_e'(rate_sel) != RATE_TOTAL);
    end

    gtc_bcd_accum #(.DIGITS(DIGITS)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .inc        (inc),
        .clr        (clr_q),
        .cnt_value  (cnt_value),
        .cnt_ovf    (cnt_ovf),
        .next_value (next_value),
        .next_ovf   (next_ovf)
    );

    gtc_result_latch #(.W(W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .load      (gate_done),
        .value_in  (next_value),
        .ovf_in    (next_ovf),
        .value_out (disp_bcd),
        .ovf_out   (disp_ovf)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (disp_bcd == '0 && !disp_ovf)); // R1
    AST_CLK_RATE_COUNTS: assert property (@(posedge clk) disable iff (rst)
        (rate_e'(rate_sel) == RATE_CLK && gate && !clr_q) |=> (cnt_value != $past(cnt_value))); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr_q) |=> $stable(cnt_value)); // R4
    AST_CLEAR_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        (clr_q && !inc) |=> (cnt_value == '0 && !cnt_ovf)); // R7
    AST_DISPLAY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !gate_done |=> ($stable(disp_bcd) && $stable(disp_ovf))); // R6

endmodule

// File: tb/gated_count_latch_bench.sv
module gated_count_latch_bench;
    localparam int DIV_MID  = 4;
    localparam int DIV_SLOW = 5;
    localparam int DIGITS   = 3;
    localparam int W        = DIGITS * 4;
    localparam int MODV     = 1000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   rate_sel = 2'b01;
    logic         gate = 1'b0;
    logic         gate_done = 1'b0;
    logic [W-1:0] disp_bcd;
    logic         disp_ovf;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    int    exp_val_q[$];
    bit    exp_ovf_q[$];
    string exp_tag_q[$];

    always #10 clk = ~clk;

    gated_count_latch #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW), .DIGITS(DIGITS)) u_gated_count_latch (
        .clk       (clk),
        .rst       (rst),
        .rate_sel  (rate_sel),
        .gate      (gate),
        .gate_done (gate_done),
        .disp_bcd  (disp_bcd),
        .disp_ovf  (disp_ovf)
    );

    function automatic logic [W-1:0] to_bcd(input int v);
        logic [W-1:0] r;
        int x;
        r = '0;
        x = v;
        for (int k = 0; k < DIGITS; k++) begin
            r[k*4 +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    task automatic check(input string tag, input int v, input bit o);
        tests++;
        if (disp_bcd !== to_bcd(v) || disp_ovf !== o) begin
            fails++;
            $display("FAIL %s: got bcd=%h ovf=%0b expected bcd=%h ovf=%0b",
                     tag, disp_bcd, disp_ovf, to_bcd(v), o);
        end
    endtask

    // monitor: pop one expectation per done pulse, compare after the latch
    always @(posedge clk) begin
        if (!rst && gate_done) begin
            @(negedge clk);
            if (exp_val_q.size() == 0) begin
                tests++;
                fails++;
                $display("FAIL R6: unexpected latch got bcd=%h expected none", disp_bcd);
            end else begin
                check(exp_tag_q.pop_front(), exp_val_q.pop_front(), exp_ovf_q.pop_front());
            end
        end
    end

    task automatic push(input int v, input bit o, input string tag);
        exp_val_q.push_back(v % MODV);
        exp_ovf_q.push_back(o);
        exp_tag_q.push_back(tag);
    endtask

    task automatic finish_meas(input int v, input bit o, input string tag);
        @(negedge clk) gate = 1'b0;
        @(negedge clk) gate_done = 1'b1;
        push(v, o, tag);
        @(negedge clk) gate_done = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic open_gate(input logic [1:0] rs, input int len);
        @(negedge clk) rate_sel = rs;
        gate = 1'b1;
        repeat (len) @(negedge clk);
        gate = 1'b0;
    endtask

    task automatic pulse_gate(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) gate = 1'b1;
            @(negedge clk);
            @(negedge clk) gate = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 during reset", 0, 1'b0);
        @(negedge clk) rst = 1'b0;
        check("R1 after reset", 0, 1'b0);

        open_gate(2'b01, 37);
        finish_meas(37, 1'b0, "R2 clock rate 37");

        open_gate(2'b10, 24);
        finish_meas(6, 1'b0, "R3 medium tick 24 cycles");

        open_gate(2'b11, 60);
        finish_meas(3, 1'b0, "R3 slow tick 60 cycles");

        @(negedge clk) rate_sel = 2'b01;
        repeat (30) @(negedge clk);
        finish_meas(0, 1'b0, "R4 clock rate gate low");
        @(negedge clk) rate_sel = 2'b10;
        repeat (30) @(negedge clk);
        finish_meas(0, 1'b0, "R4 medium rate gate low");

        // R6/R7: done on last gate-high cycle, gate stays high through the clear cycle
        @(negedge clk) rate_sel = 2'b01;
        gate = 1'b1;
        repeat (9) @(negedge clk);
        gate_done = 1'b1;
        push(10, 1'b0, "R6 done on last high cycle");
        @(negedge clk) gate_done = 1'b0;
        repeat (12) @(negedge clk);
        finish_meas(13, 1'b0, "R7 count in clear cycle kept");

        // R6 hold: gate activity without done leaves display unchanged
        open_gate(2'b01, 8);
        repeat (3) @(negedge clk);
        check("R6 display holds without done", 13, 1'b0);
        finish_meas(8, 1'b0, "R6 next latch");

        open_gate(2'b01, 999);
        finish_meas(999, 1'b0, "R8 full scale");
        open_gate(2'b01, 1003);
        finish_meas(1003, 1'b1, "R8 wrap sets overflow");
        open_gate(2'b01, 7);
        finish_meas(7, 1'b0, "R8 overflow cleared with counter");

        @(negedge clk) rate_sel = 2'b00;
        pulse_gate(3);
        finish_meas(3, 1'b0, "R5 totalize three edges");
        pulse_gate(2);
        finish_meas(5, 1'b0, "R5 totalize not cleared");
        @(negedge clk) rate_sel = 2'b01;
        finish_meas(5, 1'b0, "R5 total kept across mode change");
        open_gate(2'b01, 4);
        finish_meas(4, 1'b0, "R7 cleared after timed done");

        repeat (4) @(negedge clk);
        if (exp_val_q.size() != 0) begin
            tests++;
            fails++;
            $display("FAIL R6: got %0d pending expected 0", exp_val_q.size());
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule